// File: doc/BRIEF.md
# Multilane Pseudorandom Pattern Generator and Checker

This block drives test patterns onto a parallel electrical lane bus and checks the patterns that come back. It is meant for bring-up and screening of pluggable optics whose internal gearbox regroups the lanes. In the 100G arrangement the block runs twenty independent half-rate pattern sources, called logical lanes. Each pair is bit-interleaved onto one of ten physical lanes. Every half-rate stream then stays a valid sequence on its own after a downstream lane-ratio change. In the 40G arrangement four physical lanes each carry one full-rate sequence, with no splitting.

Each physical lane is a 2-bit slice per clock. The receive side splits the slices back into logical lanes. Each logical lane seeds itself from the incoming bits, locks on its own, and then runs its own copy of the sequence. Against that copy it counts every bit error, and it counts separately the zeros that came back as ones and the ones that came back as zeros. A per-lane start state lets neighbouring lanes run out of phase, so lanes do not mask each other's crosstalk. A fixed repeating word can replace the pseudorandom pattern on every lane.

Top module: `mlane_prbs_tester`

## Requirements
- R1: After reset every counter reads zero and every lane reports unlocked.
- R2: Pattern code 0 selects PRBS7: every logical lane's bit stream obeys b[n] = b[n-7] xor b[n-6] (x^7 + x^6 + 1).
- R3: Pattern code 1 selects PRBS31: every logical lane's bit stream obeys b[n] = b[n-31] xor b[n-28] (x^31 + x^28 + 1).
- R4: Pattern codes 2 and 3 send the 16-bit word `cfg_word` on every lane, most significant bit first, repeating without gaps from the restart.
- R5: With `cfg_mode40` = 0, logical lane 2k is carried on bit 2k of the bus (bit 0 of physical lane k) and logical lane 2k+1 on bit 2k+1 (bit 1), so logical lane i is bus bit i in both directions.
- R6: With `cfg_mode40` = 1, physical lane k < 4 (bus bits 2k and 2k+1) carries logical lane k at two bits per clock, bit 2k earlier in the sequence than bit 2k+1. Bus bits 8 to 19 transmit 0, and logical lanes 4 to 19 stay unlocked.
- R7: Each lane has a 31-bit start state written through `ofs_we`/`ofs_lane`/`ofs_val`. At a restart in PRBS31 the lane's state s becomes that value, or 1 if the value is zero. Its first bit is s[30] xor s[27], and each following bit comes from s shifted left with the new bit entering at bit 0. In PRBS7 the low 7 bits are used the same way, with taps at s[6] and s[5].
- R8: A change of mode, pattern code or word restarts every source and unlocks every checker lane at the next clock edge. The first bit of the new sequence appears on the bus after the edge following that one. The same restart takes place at the first edge after reset.
- R9: A checker lane locks only after 64 consecutive received bits agree with the sequence predicted from the bits before them.
- R10: A locked lane that sees 16 errors inside one 64-bit window drops lock. Errors arriving while a lane is unlocked change no counter.
- R11: While locked, a received 1 where 0 was expected adds one to the lane's errored-zeros count and to its total. A received 0 where 1 was expected adds one to its errored-ones count and to its total. Other lanes are unaffected. Readback selects total with `rd_sel` 0, errored zeros with 1, errored ones with 2, and returns 0 for 3.
- R12: Every counter stops at its maximum value instead of wrapping.
- R13: A one-cycle `cnt_clr` sets every counter of every lane to zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode40 | input | 1 | 0: 20 logical lanes on 10 physical; 1: 4 full-rate lanes |
| cfg_pat | input | 2 | 0 PRBS7, 1 PRBS31, 2 or 3 repeating word |
| cfg_word | input | WORD_W (16) | Word sent in word mode |
| ofs_we | input | 1 | Write strobe for a lane start state |
| ofs_lane | input | $clog2(2*PHY_LANES) (5) | Logical lane addressed by the write |
| ofs_val | input | 31 | Start state value |
| cnt_clr | input | 1 | Clear all error counters |
| tx_data | output | 2*PHY_LANES (20) | Transmit bus, 2 bits per physical lane |
| rx_data | input | 2*PHY_LANES (20) | Receive bus, same layout |
| lane_locked | output | 2*PHY_LANES (20) | Lock flag per logical lane |
| rd_lane | input | $clog2(2*PHY_LANES) (5) | Logical lane for readback |
| rd_sel | input | 2 | Counter select for readback |
| rd_data | output | CNT_W (32) | Selected counter value |

## Verification
The embedded properties guard, on every cycle, the rules that hold for any traffic. A restart or a disabled lane leaves the lane unlocked. No counter moves while its lane is unlocked. A lock rises only after a full run of good bits. Counters hold at their maximum and go to zero after a clear. Idle lanes in the 40G arrangement never lock, and a PRBS7 source never reaches the all-zero state. Only the bench scenarios can show the things that need the traffic itself. These are the tap positions of each sequence, the exact start bits after a seeded restart, the bit order on the bus in both arrangements, the word order, the split into errored zeros and errored ones under random error injection, and the lock and relock timing after a burst of errors.

// File: rtl/mlt_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the multilane pattern tester.
// Assumes every pattern source and checker keeps its history in a 31-bit
// register, newest bit at position 0.
package mlt_pkg;
    localparam int HIST_W = 31;

    // Next bit of the selected sequence, predicted from the bit history.
    function automatic logic next_bit(input logic [HIST_W-1:0] h,
                                      input logic [1:0] pat,
                                      input int word_w);
        logic r;
        if (pat[1])      r = h[word_w-1];
        else if (pat[0]) r = h[30] ^ h[27];
        else             r = h[6] ^ h[5];
        return r;
    endfunction
endpackage

// File: rtl/mlt_gen_lane.sv
`timescale 1ns/1ps
// One logical-lane pattern source. It produces one or two bits per clock
// (bits[0] first). On restart it loads its start state: the seed for the
// pseudorandom patterns, the word for word mode. It assumes restart is high
// for exactly the cycle in which the configuration changes.
module mlt_gen_lane
    import mlt_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              nb2,
    input  logic [1:0]        pat,
    input  logic [HIST_W-1:0] seed,
    input  logic [WORD_W-1:0] word,
    output logic [1:0]        bits
);
    logic [HIST_W-1:0] st;
    logic [HIST_W-1:0] st_n;
    logic [HIST_W-1:0] ld;
    logic [1:0]        o_n;
    logic              loaded;

    // Start state chosen for the selected pattern, zero replaced by one.
    always_comb begin
        if (pat[1])
            ld = HIST_W'(word);
        else if (pat[0])
            ld = (seed == '0) ? HIST_W'(1) : seed;
        else
            ld = (seed[6:0] == 7'd0) ? HIST_W'(1) : {{(HIST_W-7){1'b0}}, seed[6:0]};
    end

    // Advance the sequence by one or two bits.
    always_comb begin
        logic [HIST_W-1:0] s;
        logic b;
        s   = st;
        o_n = 2'b00;
        for (int j = 0; j < 2; j++) begin
            if (j == 0 || nb2) begin
                b      = next_bit(s, pat, WORD_W);
                o_n[j] = b;
                s      = {s[HIST_W-2:0], b};
            end
        end
        st_n = s;
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= '0;
            bits   <= 2'b00;
            loaded <= 1'b0;
        end else if (restart) begin
            st     <= ld;
            bits   <= 2'b00;
            loaded <= 1'b1;
        end else begin
            st     <= st_n;
            bits   <= o_n;
        end
    end

    // R7: a loaded PRBS7 source never falls into the all-zero state.
    a_r7_p7_state_live: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && pat == 2'b00 && !restart) |-> (st[6:0] != 7'd0));
endmodule

// File: rtl/mlt_sat_cnt.sv
`timescale 1ns/1ps
// Saturating error counter that adds 0, 1 or 2 per clock. It has a
// synchronous clear that wins over an increment in the same cycle.
module mlt_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [1:0]   inc,
    output logic [W-1:0] cnt
);
    logic [W:0] sum;

    // Wide sum so that overflow shows up in the top bit.
    always_comb sum = {1'b0, cnt} + (W+1)'(inc);

    // Count, clear or stop at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (sum[W])   cnt <= '1;
        else               cnt <= sum[W-1:0];
    end

    // R12: a counter at its maximum stays there.
    a_r12_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1 && !clr) |=> (cnt == '1));
    // R13: a clear strobe gives zero at the next edge.
    a_r13_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/mlt_chk_lane.sv
`timescale 1ns/1ps
// One logical-lane checker. While unlocked it predicts each bit from the
// bits received before it and shifts in the received bits. After LOCK_RUN
// matches in a row it locks and free-runs on its own predictions, so that
// one line error counts once. Lock state at the start of a cycle decides
// how every bit of that cycle is handled. It assumes rx[0] precedes rx[1].
module mlt_chk_lane
    import mlt_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int CNT_W     = 32,
    parameter int LOCK_RUN  = 64,
    parameter int WIN_BITS  = 64,
    parameter int LOSS_ERRS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             en,
    input  logic             nb2,
    input  logic [1:0]       pat,
    input  logic             clr,
    input  logic [1:0]       rx,
    output logic             locked,
    output logic [CNT_W-1:0] cnt_tot,
    output logic [CNT_W-1:0] cnt_zero,
    output logic [CNT_W-1:0] cnt_one
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam int WP_W  = $clog2(WIN_BITS + 1);
    localparam int WE_W  = $clog2(LOSS_ERRS + 3);

    logic [HIST_W-1:0] hist, hist_n;
    logic [RUN_W-1:0]  run_q, run_n;
    logic [WP_W-1:0]   wpos_q, wpos_n;
    logic [WE_W-1:0]   werr_q, werr_n;
    logic              lk_n;
    logic [1:0]        iz, io;
    logic [1:0]        inc_z, inc_o, inc_t;

    // Per-bit lock search, error classification and window bookkeeping.
    always_comb begin
        logic e;
        logic mis;
        hist_n = hist;
        run_n  = run_q;
        wpos_n = wpos_q;
        werr_n = werr_q;
        lk_n   = locked;
        iz     = 2'd0;
        io     = 2'd0;
        for (int j = 0; j < 2; j++) begin
            if (j == 0 || nb2) begin
                e   = next_bit(hist_n, pat, WORD_W);
                mis = rx[j] ^ e;
                if (!locked) begin
                    if (mis)                             run_n = '0;
                    else if (run_n != RUN_W'(LOCK_RUN))  run_n = run_n + 1'b1;
                    hist_n = {hist_n[HIST_W-2:0], rx[j]};
                    if (run_n == RUN_W'(LOCK_RUN)) lk_n = 1'b1;
                end else begin
                    if (mis) begin
                        if (e) io = io + 2'd1;
                        else   iz = iz + 2'd1;
                        werr_n = werr_n + 1'b1;
                    end
                    hist_n = {hist_n[HIST_W-2:0], e};
                    wpos_n = wpos_n + 1'b1;
                    if (werr_n >= WE_W'(LOSS_ERRS)) begin
                        lk_n = 1'b0;
                    end else if (wpos_n == WP_W'(WIN_BITS)) begin
                        wpos_n = '0;
                        werr_n = '0;
                    end
                end
            end
        end
    end

    // Counter increments, blocked while restarting or disabled.
    always_comb begin
        inc_z = (restart || !en) ? 2'd0 : iz;
        inc_o = (restart || !en) ? 2'd0 : io;
        inc_t = inc_z + inc_o;
    end

    // Lock, history and window registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist   <= '0;
            locked <= 1'b0;
            run_q  <= '0;
            wpos_q <= '0;
            werr_q <= '0;
        end else if (restart || !en) begin
            locked <= 1'b0;
            run_q  <= '0;
            wpos_q <= '0;
            werr_q <= '0;
        end else begin
            hist   <= hist_n;
            locked <= lk_n;
            run_q  <= locked ? '0 : run_n;
            wpos_q <= locked ? wpos_n : '0;
            werr_q <= locked ? werr_n : '0;
        end
    end

    mlt_sat_cnt #(.W(CNT_W)) u_tot  (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc_t), .cnt(cnt_tot));
    mlt_sat_cnt #(.W(CNT_W)) u_zero (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc_z), .cnt(cnt_zero));
    mlt_sat_cnt #(.W(CNT_W)) u_one  (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc_o), .cnt(cnt_one));

    // R8: a restart or a disabled lane is unlocked one edge later.
    a_r8_restart_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (restart || !en) |=> !locked);
    // R10: no counter moves while the lane is unlocked.
    a_r10_unlocked_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !clr) |=> ($stable(cnt_tot) && $stable(cnt_zero) && $stable(cnt_one)));
    // R9: lock rises only after a full run of matching bits.
    a_r9_lock_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(run_q) >= RUN_W'(LOCK_RUN - 2)));
endmodule

// File: rtl/mlane_prbs_tester.sv
`timescale 1ns/1ps
// Multilane pattern tester top. It holds the per-lane start states, detects
// configuration changes to restart all lanes, maps logical lanes to bus bits
// in both arrangements and muxes counter readback. It assumes the
// configuration inputs are stable except when deliberately changed.
module mlane_prbs_tester
    import mlt_pkg::*;
#(
    parameter int PHY_LANES = 10,
    parameter int LANES_40G = 4,
    parameter int WORD_W    = 16,
    parameter int CNT_W     = 32,
    parameter int LOCK_RUN  = 64,
    parameter int WIN_BITS  = 64,
    parameter int LOSS_ERRS = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_mode40,
    input  logic [1:0]                        cfg_pat,
    input  logic [WORD_W-1:0]                 cfg_word,
    input  logic                              ofs_we,
    input  logic [$clog2(2*PHY_LANES)-1:0]    ofs_lane,
    input  logic [HIST_W-1:0]                 ofs_val,
    input  logic                              cnt_clr,
    output logic [2*PHY_LANES-1:0]            tx_data,
    input  logic [2*PHY_LANES-1:0]            rx_data,
    output logic [2*PHY_LANES-1:0]            lane_locked,
    input  logic [$clog2(2*PHY_LANES)-1:0]    rd_lane,
    input  logic [1:0]                        rd_sel,
    output logic [CNT_W-1:0]                  rd_data
);
    localparam int LOG_LANES = 2 * PHY_LANES;
    localparam int CFG_W     = 3 + WORD_W;

    logic [HIST_W-1:0] seed_q [LOG_LANES];
    logic [CFG_W-1:0]  cfg_q;
    logic              started;
    logic              restart;
    logic [1:0]        gbits [LOG_LANES];
    logic [CNT_W-1:0]  c_tot  [LOG_LANES];
    logic [CNT_W-1:0]  c_zero [LOG_LANES];
    logic [CNT_W-1:0]  c_one  [LOG_LANES];

    // Spread default start states so lanes differ after reset.
    function automatic logic [HIST_W-1:0] seed_default(input int i);
        return HIST_W'(i * 37 + 5) ^ (HIST_W'(i) << 20);
    endfunction

    // Restart on the first cycle after reset and on any configuration change.
    always_comb restart = !started || (cfg_q != {cfg_mode40, cfg_pat, cfg_word});

    // Remember the configuration seen last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            started <= 1'b0;
        end else begin
            cfg_q   <= {cfg_mode40, cfg_pat, cfg_word};
            started <= 1'b1;
        end
    end

    // Per-lane start state storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LOG_LANES; i++) seed_q[i] <= seed_default(i);
        end else if (ofs_we && (int'(ofs_lane) < LOG_LANES)) begin
            seed_q[ofs_lane] <= ofs_val;
        end
    end

    for (genvar i = 0; i < LOG_LANES; i++) begin : g_lane
        logic [1:0] crx;
        logic       en;
        if (i < LANES_40G) begin : g_wide
            assign crx = cfg_mode40 ? rx_data[2*i+1:2*i] : {1'b0, rx_data[i]};
            assign en  = 1'b1;
        end else begin : g_narrow
            assign crx = cfg_mode40 ? 2'b00 : {1'b0, rx_data[i]};
            assign en  = !cfg_mode40;
        end

        mlt_gen_lane #(.WORD_W(WORD_W)) u_gen (
            .clk(clk), .rst_n(rst_n), .restart(restart), .nb2(cfg_mode40),
            .pat(cfg_pat), .seed(seed_q[i]), .word(cfg_word), .bits(gbits[i])
        );

        mlt_chk_lane #(
            .WORD_W(WORD_W), .CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN),
            .WIN_BITS(WIN_BITS), .LOSS_ERRS(LOSS_ERRS)
        ) u_chk (
            .clk(clk), .rst_n(rst_n), .restart(restart), .en(en), .nb2(cfg_mode40),
            .pat(cfg_pat), .clr(cnt_clr), .rx(crx), .locked(lane_locked[i]),
            .cnt_tot(c_tot[i]), .cnt_zero(c_zero[i]), .cnt_one(c_one[i])
        );
    end

    for (genvar k = 0; k < PHY_LANES; k++) begin : g_phy
        if (k < LANES_40G) begin : g_used
            assign tx_data[2*k]   = cfg_mode40 ? gbits[k][0] : gbits[2*k][0];
            assign tx_data[2*k+1] = cfg_mode40 ? gbits[k][1] : gbits[2*k+1][0];
        end else begin : g_idle
            assign tx_data[2*k]   = cfg_mode40 ? 1'b0 : gbits[2*k][0];
            assign tx_data[2*k+1] = cfg_mode40 ? 1'b0 : gbits[2*k+1][0];
        end
    end

    // Counter readback mux.
    always_comb begin
        rd_data = '0;
        if (int'(rd_lane) < LOG_LANES) begin
            case (rd_sel)
                2'd0:    rd_data = c_tot[rd_lane];
                2'd1:    rd_data = c_zero[rd_lane];
                2'd2:    rd_data = c_one[rd_lane];
                default: rd_data = '0;
            endcase
        end
    end

    // R6: lanes that carry nothing in the 40G arrangement never lock.
    a_r6_idle_lanes_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode40 |=> (lane_locked[LOG_LANES-1:LANES_40G] == '0));
endmodule

// File: tb/tb_mlane_prbs_tester.sv
`timescale 1ns/1ps
module tb_mlane_prbs_tester;
    localparam int CW  = 10;
    localparam int NL  = 20;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_mode40;
    logic [1:0]    cfg_pat;
    logic [15:0]   cfg_word;
    logic          ofs_we;
    logic [4:0]    ofs_lane;
    logic [30:0]   ofs_val;
    logic          cnt_clr;
    logic [19:0]   tx_data;
    logic [19:0]   flip;
    logic [19:0]   rx_data;
    logic [19:0]   lane_locked;
    logic [4:0]    rd_lane;
    logic [1:0]    rd_sel;
    logic [CW-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit seq [0:599];
    int ez [NL];
    int eo [NL];
    int blk [NL];

    assign rx_data = tx_data ^ flip;

    always #5 clk = ~clk;

    mlane_prbs_tester #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode40(cfg_mode40), .cfg_pat(cfg_pat),
        .cfg_word(cfg_word), .ofs_we(ofs_we), .ofs_lane(ofs_lane), .ofs_val(ofs_val),
        .cnt_clr(cnt_clr), .tx_data(tx_data), .rx_data(rx_data),
        .lane_locked(lane_locked), .rd_lane(rd_lane), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input int lane, input int sel, output int v);
        rd_lane = 5'(lane);
        rd_sel  = 2'(sel);
        #1;
        v = int'(rd_data);
    endtask

    // Count recurrence violations in seq[0..n-1] for taps ta > tb.
    function automatic int viol(input int n, input int ta, input int tb);
        int c = 0;
        for (int i = ta; i < n; i++)
            if (seq[i] != (seq[i-ta] ^ seq[i-tb])) c++;
        return c;
    endfunction

    // Bit n of a PRBS31 stream started from seed s (zero becomes one).
    function automatic bit p31_bit(input logic [30:0] s0, input int n);
        logic [30:0] s;
        bit b = 0;
        s = (s0 == '0) ? 31'd1 : s0;
        for (int i = 0; i <= n; i++) begin
            b = s[30] ^ s[27];
            s = {s[29:0], b};
        end
        return b;
    endfunction

    task automatic clear_counters();
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v, v2, v3, bad;
        logic [30:0] s6, s7;
        logic [15:0] w;
        bit e;
        void'($urandom(32'd1234));
        rst_n = 1'b0; cfg_mode40 = 1'b0; cfg_pat = 2'd0; cfg_word = 16'h0;
        ofs_we = 1'b0; ofs_lane = '0; ofs_val = '0; cnt_clr = 1'b0;
        flip = '0; rd_lane = '0; rd_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(lane_locked == '0, "R1 locks after reset", lane_locked, 0);
        rd(0, 0, v);  chk(v == 0, "R1 lane0 total after reset", v, 0);
        rd(19, 2, v); chk(v == 0, "R1 lane19 ones after reset", v, 0);

        // R2/R8: restart on first edge, first bits after the second edge
        @(negedge clk);
        @(negedge clk);
        for (int n = 0; n < 300; n++) begin seq[n] = tx_data[0]; @(negedge clk); end
        bad = viol(300, 7, 6);
        chk(bad == 0, "R2 PRBS7 recurrence lane0", bad, 0);
        for (int n = 0; n < 300; n++) begin seq[n] = tx_data[19]; @(negedge clk); end
        bad = viol(300, 7, 6);
        chk(bad == 0, "R2 PRBS7 recurrence lane19", bad, 0);

        // R9: all lanes locked in loopback
        chk(lane_locked == 20'hFFFFF, "R9 all lanes locked", lane_locked, 20'hFFFFF);
        rd(0, 0, v); chk(v == 0, "R9 no errors in clean loopback", v, 0);

        // R11/R5: one flip on bus bit 5 reaches logical lane 5 only
        e = tx_data[5];
        flip = 20'h1 << 5;
        @(negedge clk);
        flip = '0;
        rd(5, 0, v);  chk(v == 1, "R11 lane5 total", v, 1);
        rd(5, 1, v2); chk(v2 == (e ? 0 : 1), "R11 lane5 errored zeros", v2, e ? 0 : 1);
        rd(5, 2, v3); chk(v3 == (e ? 1 : 0), "R11 lane5 errored ones", v3, e ? 1 : 0);
        rd(4, 0, v);  chk(v == 0, "R5 lane4 untouched", v, 0);
        rd(5, 3, v);  chk(v == 0, "R11 select 3 reads zero", v, 0);

        // R10: burst on lane 0 drops lock, then no counting
        flip = 20'h1;
        repeat (40) @(negedge clk);
        chk(lane_locked[0] == 1'b0, "R10 lock lost on burst", lane_locked[0], 0);
        chk(lane_locked[1] == 1'b1, "R10 neighbour keeps lock", lane_locked[1], 1);
        rd(0, 0, v);
        repeat (20) @(negedge clk);
        rd(0, 0, v2);
        chk(v2 == v, "R10 no count while unlocked", v2, v);
        flip = '0;
        repeat (50) @(negedge clk);
        chk(lane_locked[0] == 1'b0, "R9 no relock before 64 good bits", lane_locked[0], 0);
        repeat (50) @(negedge clk);
        chk(lane_locked[0] == 1'b1, "R9 relock after clean run", lane_locked[0], 1);

        // R11: random sparse errors, classified per lane
        clear_counters();
        for (int i = 0; i < NL; i++) begin ez[i] = 0; eo[i] = 0; blk[i] = 0; end
        for (int c = 0; c < 3000; c++) begin
            logic [19:0] f;
            f = '0;
            if (c % 64 == 0) for (int i = 0; i < NL; i++) blk[i] = 0;
            for (int i = 0; i < NL; i++) begin
                if (($urandom % 64) == 0 && blk[i] < 7) begin
                    f[i] = 1'b1;
                    blk[i]++;
                    if (tx_data[i]) eo[i]++; else ez[i]++;
                end
            end
            flip = f;
            @(negedge clk);
        end
        flip = '0;
        chk(lane_locked == 20'hFFFFF, "R11 lanes stay locked under sparse errors", lane_locked, 20'hFFFFF);
        bad = 0;
        for (int i = 0; i < NL; i++) begin
            rd(i, 1, v);  if (v != ez[i]) bad++;
            rd(i, 2, v2); if (v2 != eo[i]) bad++;
            rd(i, 0, v3); if (v3 != ez[i] + eo[i]) bad++;
        end
        chk(bad == 0, "R11 random error classification mismatches", bad, 0);

        // R13: clear
        clear_counters();
        bad = 0;
        for (int i = 0; i < NL; i++) for (int s = 0; s < 3; s++) begin rd(i, s, v); if (v != 0) bad++; end
        chk(bad == 0, "R13 nonzero counters after clear", bad, 0);

        // R7/R8/R3: seeded restart into PRBS31
        s6 = 31'($urandom);
        s7 = 31'($urandom);
        ofs_we = 1'b1; ofs_lane = 5'd6; ofs_val = s6; @(negedge clk);
        ofs_lane = 5'd7; ofs_val = s7; @(negedge clk);
        ofs_lane = 5'd8; ofs_val = '0; @(negedge clk);
        ofs_we = 1'b0;
        cfg_pat = 2'd1;
        @(negedge clk);
        chk(lane_locked == '0, "R8 pattern change unlocks all", lane_locked, 0);
        @(negedge clk);
        v = 0; v2 = 0; v3 = 0;
        for (int n = 0; n < 300; n++) begin
            if (n < 40) begin
                if (tx_data[6] != p31_bit(s6, n)) v++;
                if (tx_data[7] != p31_bit(s7, n)) v2++;
                if (tx_data[8] != p31_bit(31'd0, n)) v3++;
            end
            seq[n] = tx_data[13];
            @(negedge clk);
        end
        chk(v == 0, "R7 lane6 seeded start", v, 0);
        chk(v2 == 0, "R7 lane7 seeded start", v2, 0);
        chk(v3 == 0, "R7 zero seed acts as one", v3, 0);
        bad = viol(300, 31, 28);
        chk(bad == 0, "R3 PRBS31 recurrence lane13", bad, 0);
        chk(lane_locked == 20'hFFFFF, "R3 all lanes locked on PRBS31", lane_locked, 20'hFFFFF);

        // R6: 40G arrangement
        cfg_mode40 = 1'b1;
        @(negedge clk);
        chk(lane_locked == '0, "R8 mode change unlocks all", lane_locked, 0);
        @(negedge clk);
        bad = 0;
        for (int n = 0; n < 200; n++) begin
            seq[2*n] = tx_data[2];
            seq[2*n+1] = tx_data[3];
            if (tx_data[19:8] != '0) bad++;
            @(negedge clk);
        end
        v = viol(400, 31, 28);
        chk(v == 0, "R6 two-bit order on physical lane 1", v, 0);
        chk(bad == 0, "R6 idle physical lanes drive zero", bad, 0);
        chk(lane_locked == 20'h0000F, "R6 only four lanes locked", lane_locked, 20'h0000F);
        clear_counters();
        flip = 20'h0000C;
        @(negedge clk);
        flip = '0;
        rd(1, 0, v);  chk(v == 2, "R6 two errors in one clock on lane 1", v, 2);
        rd(0, 0, v2); chk(v2 == 0, "R6 lane 0 untouched", v2, 0);

        // R4: word mode
        w = 16'($urandom);
        cfg_mode40 = 1'b0;
        cfg_pat = 2'd2;
        cfg_word = w;
        @(negedge clk);
        @(negedge clk);
        bad = 0;
        for (int n = 0; n < 48; n++) begin
            if (tx_data[7] != w[15 - (n % 16)]) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R4 word order on lane 7", bad, 0);
        repeat (60) @(negedge clk);
        chk(lane_locked == 20'hFFFFF, "R4 all lanes locked on word", lane_locked, 20'hFFFFF);
        clear_counters();
        flip = 20'h4;
        @(negedge clk);
        flip = '0;
        rd(2, 0, v); chk(v == 1, "R4 word error counted once", v, 1);

        // R12: saturation
        cfg_pat = 2'd0;
        repeat (120) @(negedge clk);
        clear_counters();
        ez[0] = 0; eo[0] = 0;
        for (int c = 0; c < 8400; c++) begin
            if (c % 8 == 0) begin
                flip = 20'hFFFFF;
                if (tx_data[0]) eo[0]++; else ez[0]++;
            end else begin
                flip = '0;
            end
            @(negedge clk);
        end
        flip = '0;
        rd(0, 0, v);  chk(v == MAXC, "R12 lane0 total saturates", v, MAXC);
        rd(19, 0, v); chk(v == MAXC, "R12 lane19 total saturates", v, MAXC);
        rd(0, 1, v);  chk(v == ez[0], "R12 lane0 zeros below max", v, ez[0]);
        rd(0, 2, v);  chk(v == eo[0], "R12 lane0 ones below max", v, eo[0]);
        clear_counters();
        rd(0, 0, v); chk(v == 0, "R13 clear after saturation", v, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule